// File: doc/BRIEF.md
# Four-Neighbour Bilinear Pixel Blender

This block takes the four source pixels that surround a sampling point (top-left, top-right, bottom-left, bottom-right) and two fractional weights. One weight gives the horizontal offset of the point inside the 2x2 neighbourhood and the other gives the vertical offset. It returns one pixel that is the weighted mean of the four neighbours. Each colour channel of a packed pixel is blended separately, with its own copy of the arithmetic.

The block fits into a resampling chain for rotation, zoom or crop. An upstream address generator finds the neighbours and the weights, and a memory reader fetches the pixels. This block does only the arithmetic. Samples arrive on a valid-qualified stream, at most one per cycle. Results come out a fixed number of cycles later with their own valid flag. The address generator can flag a sample as lying outside the source image. Such a sample is emitted as a black background pixel.

Top module: `bilinear_quad_interp`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `outValid` is 0 and `outPixel` is all zeros.
- R2: A sample accepted with `inValid` high at a rising edge appears with `outValid` high exactly three rising edges later. Samples on consecutive cycles produce results on consecutive cycles, in the same order.
- R3: Each weight is a 7-bit unsigned fraction: code w means w/128, for codes 0 to 127. With both weights at 0, the result equals the top-left neighbour exactly.
- R4: For each channel: top = TL*(128-dc) + TR*dc and bottom = BL*(128-dc) + BR*dc. The result is (top*(128-dr) + bottom*dr + 8192) >> 14, which rounds to the nearest value with ties going up.
- R5: Channel c occupies bits [c*8 +: 8] of every pixel bus, with channel 0 in the least significant byte. A channel's result depends only on that channel's neighbours.
- R6: A valid sample with `inOutOfRange` high produces an all-zero pixel, whatever neighbour values come with it.
- R7: While `outValid` is low, `outPixel` keeps the last valid result. A cycle with `inValid` low changes nothing, whatever the other inputs carry, and this includes `inOutOfRange`.
- R8: When all four neighbours of a channel are equal, the result for that channel is that value, for any pair of weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Sample present on the inputs this cycle |
| inOutOfRange | input | 1 | Sample lies outside the source image; emit background |
| inTopLeft | input | 24 | Top-left neighbour, packed channels |
| inTopRight | input | 24 | Top-right neighbour, packed channels |
| inBotLeft | input | 24 | Bottom-left neighbour, packed channels |
| inBotRight | input | 24 | Bottom-right neighbour, packed channels |
| inDeltaCol | input | 7 | Horizontal weight, code/128 |
| inDeltaRow | input | 7 | Vertical weight, code/128 |
| outValid | output | 1 | Result present on `outPixel` |
| outPixel | output | 24 | Blended pixel, packed channels |

## Verification
The properties assume that inputs are fully defined on every rising edge and that `inValid` is held low throughout reset. They also rely on the three-cycle history after reset, counted inside the checker, so that a comparison never reaches back to an input from before reset. The bench drives every input on the falling edge. It holds `inValid` low while `rstN` is low, and it fills the neighbour and weight lines with unrelated values on idle cycles. This keeps the stimulus inside those assumptions and still exercises the rule that idle inputs are ignored.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;

  // Per-cycle strobes from the control pipe to the arithmetic lanes
  typedef struct packed {
    logic s1En;     // capture horizontal blends
    logic s2En;     // capture vertical products
    logic s3En;     // capture final pixel
    logic s3Blank;  // final pixel is the background value
  } stageCtl_t;

endpackage

// File: rtl/bilerp_ctrl.sv
module bilerp_ctrl
  import bilerp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inOutOfRange,
  output stageCtl_t ctl,
  output logic      outValid
);

  logic vld1, vld2, vld3;
  logic blank1, blank2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld1   <= 1'b0;
      vld2   <= 1'b0;
      vld3   <= 1'b0;
      blank1 <= 1'b0;
      blank2 <= 1'b0;
    end else begin
      vld1   <= inValid;
      blank1 <= inValid & inOutOfRange;
      vld2   <= vld1;
      blank2 <= blank1;
      vld3   <= vld2;
    end
  end

  always_comb begin
    ctl.s1En    = inValid;
    ctl.s2En    = vld1;
    ctl.s3En    = vld2;
    ctl.s3Blank = blank2;
    outValid    = vld3;
  end

endmodule

// File: rtl/bilerp_lane.sv
module bilerp_lane
  import bilerp_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageCtl_t         ctl,
  input  logic [PIX_W-1:0]  tl,
  input  logic [PIX_W-1:0]  tr,
  input  logic [PIX_W-1:0]  bl,
  input  logic [PIX_W-1:0]  br,
  input  logic [FRAC_W-1:0] dc,
  input  logic [FRAC_W-1:0] drHeld,
  output logic [PIX_W-1:0]  pix
);

  localparam int ONE   = 1 << FRAC_W;
  localparam int HW    = PIX_W + FRAC_W;       // horizontal blend width
  localparam int PW2   = PIX_W + 2 * FRAC_W;   // vertical product / sum width
  localparam int SHIFT = 2 * FRAC_W;
  localparam logic [PW2-1:0] RND = PW2'(1) << (SHIFT - 1);

  // Stage 1: horizontal blends of top and bottom rows
  logic [FRAC_W:0] dcW, dcC;
  logic [HW-1:0]   topNext, botNext;
  logic [HW-1:0]   topR, botR;

  always_comb begin
    dcW     = {1'b0, dc};
    dcC     = (FRAC_W + 1)'(ONE) - dcW;
    topNext = HW'(tl) * HW'(dcC) + HW'(tr) * HW'(dcW);
    botNext = HW'(bl) * HW'(dcC) + HW'(br) * HW'(dcW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topR <= '0;
      botR <= '0;
    end else if (ctl.s1En) begin
      topR <= topNext;
      botR <= botNext;
    end
  end

  // Stage 2: vertical weighting products
  logic [FRAC_W:0] drW, drC;
  logic [PW2-1:0]  prodTop, prodBot;
  logic [PW2-1:0]  prodTopR, prodBotR;

  always_comb begin
    drW     = {1'b0, drHeld};
    drC     = (FRAC_W + 1)'(ONE) - drW;
    prodTop = PW2'(topR) * PW2'(drC);
    prodBot = PW2'(botR) * PW2'(drW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodTopR <= '0;
      prodBotR <= '0;
    end else if (ctl.s2En) begin
      prodTopR <= prodTop;
      prodBotR <= prodBot;
    end
  end

  // Stage 3: sum, round, rescale, background override
  logic [PIX_W-1:0] pixNext;

  always_comb begin
    if (ctl.s3Blank) pixNext = '0;
    else             pixNext = PIX_W'((prodTopR + prodBotR + RND) >> SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          pix <= '0;
    else if (ctl.s3En)  pix <= pixNext;
  end

endmodule

// File: rtl/bilerp_datapath.sv
module bilerp_datapath
  import bilerp_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 3,
  parameter int FRAC_W   = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  stageCtl_t                   ctl,
  input  logic [PIX_W*CHANNELS-1:0]   tlBus,
  input  logic [PIX_W*CHANNELS-1:0]   trBus,
  input  logic [PIX_W*CHANNELS-1:0]   blBus,
  input  logic [PIX_W*CHANNELS-1:0]   brBus,
  input  logic [FRAC_W-1:0]           dc,
  input  logic [FRAC_W-1:0]           dr,
  output logic [PIX_W*CHANNELS-1:0]   pixBus
);

  // Vertical weight is first used in stage 2; one shared copy for all lanes
  logic [FRAC_W-1:0] drHeld;

  always_ff @(posedge clk) begin
    if (!rstN)          drHeld <= '0;
    else if (ctl.s1En)  drHeld <= dr;
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
    bilerp_lane #(
      .PIX_W (PIX_W),
      .FRAC_W(FRAC_W)
    ) u_lane (
      .clk   (clk),
      .rstN  (rstN),
      .ctl   (ctl),
      .tl    (tlBus[ch*PIX_W +: PIX_W]),
      .tr    (trBus[ch*PIX_W +: PIX_W]),
      .bl    (blBus[ch*PIX_W +: PIX_W]),
      .br    (brBus[ch*PIX_W +: PIX_W]),
      .dc    (dc),
      .drHeld(drHeld),
      .pix   (pixBus[ch*PIX_W +: PIX_W])
    );
  end

endmodule

// File: rtl/bilinear_quad_interp.sv
module bilinear_quad_interp
  import bilerp_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 3,
  parameter int FRAC_W   = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic                      inOutOfRange,
  input  logic [PIX_W*CHANNELS-1:0] inTopLeft,
  input  logic [PIX_W*CHANNELS-1:0] inTopRight,
  input  logic [PIX_W*CHANNELS-1:0] inBotLeft,
  input  logic [PIX_W*CHANNELS-1:0] inBotRight,
  input  logic [FRAC_W-1:0]         inDeltaCol,
  input  logic [FRAC_W-1:0]         inDeltaRow,
  output logic                      outValid,
  output logic [PIX_W*CHANNELS-1:0] outPixel
);

  stageCtl_t ctl;

  bilerp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inOutOfRange(inOutOfRange),
    .ctl         (ctl),
    .outValid    (outValid)
  );

  bilerp_datapath #(
    .PIX_W   (PIX_W),
    .CHANNELS(CHANNELS),
    .FRAC_W  (FRAC_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .tlBus (inTopLeft),
    .trBus (inTopRight),
    .blBus (inBotLeft),
    .brBus (inBotRight),
    .dc    (inDeltaCol),
    .dr    (inDeltaRow),
    .pixBus(outPixel)
  );

endmodule

// File: rtl/bilerp_chk.sv
module bilerp_chk #(
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 3,
  parameter int FRAC_W   = 7
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inValid,
  input logic                      inOutOfRange,
  input logic [PIX_W*CHANNELS-1:0] inTopLeft,
  input logic [PIX_W*CHANNELS-1:0] inTopRight,
  input logic [PIX_W*CHANNELS-1:0] inBotLeft,
  input logic [PIX_W*CHANNELS-1:0] inBotRight,
  input logic [FRAC_W-1:0]         inDeltaCol,
  input logic [FRAC_W-1:0]         inDeltaRow,
  input logic                      outValid,
  input logic [PIX_W*CHANNELS-1:0] outPixel
);

  // Cycles since reset, saturating at the pipeline depth
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rstN)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && outPixel == '0));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R3
  corner_tl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && outValid && !$past(inOutOfRange, 3) &&
     $past(inDeltaCol, 3) == '0 && $past(inDeltaRow, 3) == '0)
    |-> (outPixel == $past(inTopLeft, 3)));

  // R6
  blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && outValid && $past(inOutOfRange, 3)) |-> (outPixel == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0 && !outValid) |-> $stable(outPixel));

  // R8
  uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && outValid && !$past(inOutOfRange, 3) &&
     $past(inTopLeft, 3) == $past(inTopRight, 3) &&
     $past(inTopLeft, 3) == $past(inBotLeft, 3) &&
     $past(inTopLeft, 3) == $past(inBotRight, 3))
    |-> (outPixel == $past(inTopLeft, 3)));

endmodule

bind bilinear_quad_interp bilerp_chk #(
  .PIX_W   (PIX_W),
  .CHANNELS(CHANNELS),
  .FRAC_W  (FRAC_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inOutOfRange(inOutOfRange),
  .inTopLeft   (inTopLeft),
  .inTopRight  (inTopRight),
  .inBotLeft   (inBotLeft),
  .inBotRight  (inBotRight),
  .inDeltaCol  (inDeltaCol),
  .inDeltaRow  (inDeltaRow),
  .outValid    (outValid),
  .outPixel    (outPixel)
);

// File: tb/bilinear_quad_interp_tb.sv
`timescale 1ns/1ps
module bilinear_quad_interp_tb;

  localparam int PW  = 8;
  localparam int CH  = 3;
  localparam int FW  = 7;
  localparam int BW  = PW * CH;
  localparam int ONE = 1 << FW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          inValid, inOutOfRange;
  logic [BW-1:0] inTopLeft, inTopRight, inBotLeft, inBotRight;
  logic [FW-1:0] inDeltaCol, inDeltaRow;
  logic          outValid;
  logic [BW-1:0] outPixel;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;   // 50 MHz

  bilinear_quad_interp #(.PIX_W(PW), .CHANNELS(CH), .FRAC_W(FW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOutOfRange(inOutOfRange),
    .inTopLeft(inTopLeft), .inTopRight(inTopRight),
    .inBotLeft(inBotLeft), .inBotRight(inBotRight),
    .inDeltaCol(inDeltaCol), .inDeltaRow(inDeltaRow),
    .outValid(outValid), .outPixel(outPixel)
  );

  // Expected-result history: index 2 is the stimulus from three steps ago
  logic          hV[3];
  logic [BW-1:0] hP[3];
  string         hT[3];
  logic [BW-1:0] lastExp;
  logic [31:0]   seed = 32'h1234_5678;

  function automatic logic [BW-1:0] blend(input logic [BW-1:0] a, b, c, d,
                                          input int dc, dr);
    logic [BW-1:0] res;
    for (int k = 0; k < CH; k++) begin
      int top, bot, r;
      top = int'(a[k*PW +: PW]) * (ONE - dc) + int'(b[k*PW +: PW]) * dc;
      bot = int'(c[k*PW +: PW]) * (ONE - dc) + int'(d[k*PW +: PW]) * dc;
      r   = (top * (ONE - dr) + bot * dr + 8192) / 16384;
      res[k*PW +: PW] = PW'(r);
    end
    return res;
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic checkNow(input string tag, input logic expV, input logic [BW-1:0] expP);
    checks++;
    if (outValid !== expV || outPixel !== expP) begin
      fails++;
      $display("FAIL %s: actual valid=%0b pixel=%h, expected valid=%0b pixel=%h",
               tag, outValid, outPixel, expV, expP);
    end
  endtask

  // One cycle: check the result due now, then drive the next sample
  task automatic step(input logic v, oor, input logic [BW-1:0] a, b, c, d,
                      input int dc, dr, input string tag);
    logic [BW-1:0] e;
    @(negedge clk);
    if (hV[2]) lastExp = hP[2];
    checkNow(hT[2], hV[2], lastExp);
    inValid = v; inOutOfRange = oor;
    inTopLeft = a; inTopRight = b; inBotLeft = c; inBotRight = d;
    inDeltaCol = FW'(dc); inDeltaRow = FW'(dr);
    e = (v && oor) ? '0 : blend(a, b, c, d, dc, dr);
    hV[2] = hV[1]; hP[2] = hP[1]; hT[2] = hT[1];
    hV[1] = hV[0]; hP[1] = hP[0]; hT[1] = hT[0];
    hV[0] = v;     hP[0] = e;     hT[0] = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      seed = nextRand(seed);
      step(1'b0, seed[3], {seed[23:0]}, ~seed[23:0], {seed[7:0], seed[31:16]},
           seed[31:8], int'(seed[6:0]), int'(seed[13:7]), tag);
    end
  endtask

  task automatic tReset();
    rstN = 1'b0; inValid = 1'b0; inOutOfRange = 1'b0;
    inTopLeft = '1; inTopRight = '1; inBotLeft = '1; inBotRight = '1;
    inDeltaCol = '0; inDeltaRow = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkNow("R1", 1'b0, '0);
    end
    rstN = 1'b1;
    @(negedge clk);
    checkNow("R1", 1'b0, '0);   // first cycle after release
    for (int i = 0; i < 3; i++) begin hV[i] = 1'b0; hP[i] = '0; hT[i] = "R1"; end
    lastExp = '0;
  endtask

  task automatic tCorners();
    logic [BW-1:0] a = 24'h10_20_30, b = 24'hF0_80_40, c = 24'h05_FF_99, d = 24'h7A_00_C3;
    step(1'b1, 1'b0, a, b, c, d, 0,   0,   "R3");
    step(1'b1, 1'b0, a, b, c, d, 127, 0,   "R3");
    step(1'b1, 1'b0, a, b, c, d, 0,   127, "R3");
    step(1'b1, 1'b0, a, b, c, d, 127, 127, "R3");
    step(1'b1, 1'b0, a, b, c, d, 64,  64,  "R4");
    step(1'b1, 1'b0, 24'h00_00_01, 24'h00_00_00, 24'h00_00_00, 24'h00_00_00, 64, 64, "R4");
    step(1'b1, 1'b0, 24'h00_00_02, 24'h00_00_00, 24'h00_00_00, 24'h00_00_00, 64, 64, "R4");
    step(1'b1, 1'b0, '1, '1, '1, 24'h00_00_00, 127, 127, "R4");
    idle(3, "R3");
  endtask

  task automatic tStream();
    for (int i = 0; i < 40; i++) begin
      logic [BW-1:0] a, b, c, d;
      seed = nextRand(seed); a = seed[31:8];
      seed = nextRand(seed); b = seed[31:8];
      seed = nextRand(seed); c = seed[31:8];
      seed = nextRand(seed); d = seed[31:8];
      seed = nextRand(seed);
      step(1'b1, 1'b0, a, b, c, d, int'(seed[20:14]), int'(seed[29:23]), "R2");
    end
    // gaps between samples
    step(1'b1, 1'b0, 24'h11_22_33, 24'h44_55_66, 24'h77_88_99, 24'hAA_BB_CC, 30, 90, "R2");
    idle(1, "R2");
    step(1'b1, 1'b0, 24'hC0_40_10, 24'h0F_F0_3C, 24'h9E_21_77, 24'h02_D4_58, 100, 5, "R4");
    idle(2, "R2");
  endtask

  task automatic tChannels();
    for (int k = 0; k < CH; k++) begin
      logic [BW-1:0] a = '0, b = '0, c = '0, d = '0;
      a[k*PW +: PW] = 8'hC8; b[k*PW +: PW] = 8'h14;
      c[k*PW +: PW] = 8'h5A; d[k*PW +: PW] = 8'hFF;
      step(1'b1, 1'b0, a, b, c, d, 37, 101, "R5");
    end
    idle(3, "R5");
  endtask

  task automatic tOutOfRange();
    step(1'b1, 1'b0, 24'h80_80_80, 24'h80_80_80, 24'hFF_FF_FF, 24'hFF_FF_FF, 10, 20, "R4");
    step(1'b1, 1'b1, '1, '1, '1, '1, 0, 0, "R6");
    step(1'b1, 1'b1, 24'h12_34_56, 24'hAB_CD_EF, 24'h99_88_77, 24'h01_02_03, 77, 33, "R6");
    step(1'b1, 1'b0, 24'h01_02_03, 24'h04_05_06, 24'h07_08_09, 24'h0A_0B_0C, 64, 64, "R6");
    idle(3, "R6");
  endtask

  task automatic tHold();
    step(1'b1, 1'b0, 24'h3C_5A_7E, 24'h11_EE_42, 24'hA0_0B_C4, 24'h66_99_D2, 55, 70, "R7");
    idle(8, "R7");   // idle cycles carry random neighbours and out-of-range
    step(1'b1, 1'b0, 24'h00_FF_00, 24'hFF_00_FF, 24'h80_80_80, 24'h40_C0_20, 120, 9, "R7");
    idle(5, "R7");
  endtask

  task automatic tUniform();
    step(1'b1, 1'b0, 24'hFF_00_7F, 24'hFF_00_7F, 24'hFF_00_7F, 24'hFF_00_7F, 127, 1, "R8");
    step(1'b1, 1'b0, 24'h01_FE_80, 24'h01_FE_80, 24'h01_FE_80, 24'h01_FE_80, 63, 127, "R8");
    step(1'b1, 1'b0, 24'hFF_FF_FF, 24'hFF_FF_FF, 24'hFF_FF_FF, 24'hFF_FF_FF, 99, 99, "R8");
    idle(3, "R8");
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tReset();
    tCorners();
    tStream();
    tChannels();
    tOutOfRange();
    tHold();
    tUniform();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule